// File: doc/BRIEF.md
# Floating Divider Issue and Stall Controller

This block schedules a single iterative floating-point divider that shares one issue slot with the floating add pipeline. Each cycle it receives at most one divide request, tagged single or double precision, and one add-class request (add, subtract, sign copy, convert, conditional move). It decides which of them issues, tracks how long the divider stays occupied, and raises a one-cycle global issue stall when the quotient is ready. During that stall the quotient passes through the rounding adder to the register file.

The divider stays busy for a fixed count that depends on precision. While it runs, add-class work keeps issuing through the shared slot. When the quotient appears, the divider takes the write-back path and add-class requests are refused for that cycle. A new divide may issue in that same cycle, so divides can run back to back with no idle gap. Only the timing and the handshake are modelled; no quotient is computed.

Top module: `fdiv_issue_ctl`

## Requirements
- R1: After synchronous reset, div_busy, div_remain and issue_stall are all 0.
- R2: A divide request seen while div_remain is 0 is granted in that cycle. In the next cycle div_remain reads 18 when div_dbl was 0 (single precision) and 30 when div_dbl was 1 (double precision).
- R3: While no new divide is granted, div_remain falls by one each cycle until it reaches 0. div_busy is 1 exactly when div_remain is non-zero.
- R4: issue_stall is 1 exactly in the cycle where div_remain is 1. That is 18 or 30 cycles after the grant, and it lasts one cycle.
- R5: A divide request is refused while div_remain is greater than 1.
- R6: A divide request in the stall cycle is granted, and div_remain reloads in the next cycle with no idle cycle between the two divides.
- R7: An add-class request is granted whenever there is no stall and no divide grant in the same cycle, including while a divide is in progress.
- R8: During the stall cycle add-class requests are refused, wb_from_div is 1 and wb_from_add is 0. Outside the stall wb_from_div is 0 and wb_from_add equals add_grant.
- R9: When a divide and an add-class request compete for the shared slot, the divide wins and add_grant is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_req | input | 1 | Divide wants to issue this cycle |
| div_dbl | input | 1 | Precision of the divide: 1 double, 0 single |
| add_req | input | 1 | Add-class operation wants to issue this cycle |
| div_grant | output | 1 | Divide issues this cycle |
| add_grant | output | 1 | Add-class operation issues this cycle |
| div_busy | output | 1 | Divider occupied |
| div_remain | output | CW (5) | Cycles of occupancy left |
| issue_stall | output | 1 | One-cycle global issue stall at quotient ready |
| wb_from_div | output | 1 | Divider owns the write-back path |
| wb_from_add | output | 1 | Add pipe owns the write-back path |

## Verification
The bench aims at the completion cycle. It drives divide and add requests there together and checks that the new divide is granted, the add is refused, and the counter reloads with no gap. A design that is off by one in the stall decode would stall a cycle early or late, or grant the add while the divider owns write-back. The bench also sends divide requests through the whole busy window: a controller that compares against 0 instead of 1 would refuse the back-to-back divide. It uses both precisions, so a swapped load value shows up as a wrong remaining count. It also sends simultaneous requests while idle, which shows whether the shared slot gives priority to the divide.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic {PREC_S = 1'b0, PREC_D = 1'b1} prec_e;

  function automatic int unsigned occ_of(prec_e p, int unsigned s, int unsigned d);
    return (p == PREC_D) ? d : s;
  endfunction
endpackage

// File: rtl/fdiv_occ_ctr.sv
module fdiv_occ_ctr
  import fdiv_pkg::*;
#(
  parameter int unsigned SGL_CYC = 18,
  parameter int unsigned DBL_CYC = 30,
  parameter int unsigned CW      = $clog2(DBL_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          dbl,
  output logic [CW-1:0] remain,
  output logic          busy,
  output logic          stall
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, stall_q;

  always_comb begin
    if (load)
      cnt_n = CW'(occ_of(prec_e'(dbl), SGL_CYC, DBL_CYC));
    else if (cnt_q != '0)
      cnt_n = cnt_q - ONE;
    else
      cnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      busy_q  <= (cnt_n != '0);
      stall_q <= (cnt_n == ONE);
    end
  end

  assign remain = cnt_q;
  assign busy   = busy_q;
  assign stall  = stall_q;

  // R4
  stall_single_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  // R3
  busy_match_chk: assert property (@(posedge clk) disable iff (rst)
    busy == (remain != '0));
endmodule

// File: rtl/fdiv_slot_arb.sv
module fdiv_slot_arb #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          div_req,
  input  logic          add_req,
  input  logic [CW-1:0] remain,
  input  logic          stall,
  output logic          div_grant,
  output logic          add_grant
);
  logic div_free;

  assign div_free  = (remain <= CW'(1));
  assign div_grant = div_req & div_free;
  assign add_grant = add_req & ~div_grant & ~stall;

  // R8
  add_block_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> !add_grant);

  // R5
  no_busy_grant_chk: assert property (@(posedge clk) disable iff (rst)
    div_grant |-> (remain <= CW'(1)));

  // R9
  slot_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(div_grant && add_grant));
endmodule

// File: rtl/fdiv_issue_ctl.sv
module fdiv_issue_ctl #(
  parameter int unsigned SGL_CYC = 18,
  parameter int unsigned DBL_CYC = 30,
  parameter int unsigned CW      = $clog2(DBL_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          div_req,
  input  logic          div_dbl,
  input  logic          add_req,
  output logic          div_grant,
  output logic          add_grant,
  output logic          div_busy,
  output logic [CW-1:0] div_remain,
  output logic          issue_stall,
  output logic          wb_from_div,
  output logic          wb_from_add
);
  logic [CW-1:0] remain_w;
  logic          stall_w, busy_w, dgnt_w, agnt_w;

  fdiv_occ_ctr #(.SGL_CYC(SGL_CYC), .DBL_CYC(DBL_CYC), .CW(CW)) u_ctr (
    .clk(clk), .rst(rst), .load(dgnt_w), .dbl(div_dbl),
    .remain(remain_w), .busy(busy_w), .stall(stall_w)
  );

  fdiv_slot_arb #(.CW(CW)) u_arb (
    .clk(clk), .rst(rst), .div_req(div_req), .add_req(add_req),
    .remain(remain_w), .stall(stall_w),
    .div_grant(dgnt_w), .add_grant(agnt_w)
  );

  assign div_grant   = dgnt_w;
  assign add_grant   = agnt_w;
  assign div_busy    = busy_w;
  assign div_remain  = remain_w;
  assign issue_stall = stall_w;
  assign wb_from_div = stall_w;
  assign wb_from_add = agnt_w;

  // R2
  load_val_chk: assert property (@(posedge clk) disable iff (rst)
    div_grant |=> div_remain == ($past(div_dbl) ? CW'(DBL_CYC) : CW'(SGL_CYC)));

  // R3
  countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (div_remain != '0 && !div_grant) |=> div_remain == $past(div_remain) - CW'(1));

  // R4
  stall_at_one_chk: assert property (@(posedge clk) disable iff (rst)
    issue_stall == (div_remain == CW'(1)));

  // R8
  wb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wb_from_div && wb_from_add));
endmodule

// File: tb/sim_fdiv_issue_ctl.sv
module sim_fdiv_issue_ctl;
  localparam int CW = 5;
  localparam int SGL = 18;
  localparam int DBL = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic div_req = 1'b0, div_dbl = 1'b0, add_req = 1'b0;
  logic div_grant, add_grant, div_busy, issue_stall, wb_from_div, wb_from_add;
  logic [CW-1:0] div_remain;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    int  rem;
    bit  dg, ag, stall;
    string rtag;
  } exp_t;

  exp_t q[$];
  int er = 0;
  string next_rtag = "R3";

  always #2 clk = ~clk;

  fdiv_issue_ctl u0 (
    .clk(clk), .rst(rst), .div_req(div_req), .div_dbl(div_dbl), .add_req(add_req),
    .div_grant(div_grant), .add_grant(add_grant), .div_busy(div_busy),
    .div_remain(div_remain), .issue_stall(issue_stall),
    .wb_from_div(wb_from_div), .wb_from_add(wb_from_add)
  );

  task automatic chk(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes what must come out
  task automatic step(bit d, bit dbl, bit a);
    exp_t e;
    @(negedge clk);
    div_req = d; div_dbl = dbl; add_req = a;
    e.rem   = er;
    e.stall = (er == 1);
    e.dg    = d && (er <= 1);
    e.ag    = a && !e.dg && !e.stall;
    e.rtag  = next_rtag;
    q.push_back(e);
    if (e.dg) begin
      next_rtag = e.stall ? "R6" : "R2";
      er = dbl ? DBL : SGL;
    end else begin
      next_rtag = "R3";
      er = (er > 0) ? er - 1 : 0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.rtag, int'(div_remain), e.rem);
      chk("R3 busy", int'(div_busy), int'(e.rem != 0));
      chk("R4 stall", int'(issue_stall), int'(e.stall));
      chk(e.stall ? "R6 div_grant" : (e.rem > 1 ? "R5 div_grant" : "R2 div_grant"),
          int'(div_grant), int'(e.dg));
      chk(e.stall ? "R8 add_grant" : (e.dg ? "R9 add_grant" : "R7 add_grant"),
          int'(add_grant), int'(e.ag));
      chk("R8 wb_from_div", int'(wb_from_div), int'(e.stall));
      chk("R8 wb_from_add", int'(wb_from_add), int'(e.ag));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R1 busy", int'(div_busy), 0);
    chk("R1 remain", int'(div_remain), 0);
    chk("R1 stall", int'(issue_stall), 0);
    // idle with adds
    step(0, 0, 1);
    step(0, 0, 0);
    // simultaneous divide and add while idle: R9
    step(1, 0, 1);
    // single-precision run with adds all through and divide requests refused (R5, R7)
    for (int i = 0; i < 17; i++) step(i % 3 == 0, 1, 1);
    // now in the stall cycle: divide and add together -> back-to-back double (R6, R8)
    step(1, 1, 1);
    for (int i = 0; i < 29; i++) step(i % 5 == 0, 0, i % 2);
    // stall cycle with only an add: refused (R8)
    step(0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    // double-precision from idle, drain to idle
    step(1, 1, 0);
    for (int i = 0; i < 33; i++) step(0, 0, i % 4 == 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule